// File: doc/BRIEF.md
# Hot-Plug Slot Event Interrupt Controller

This block gathers the sideband signals of every slot on a multi-slot hot-plug bridge and turns them into interrupt and system-error requests. For each slot it synchronises the retention-latch sensor, the attention button, the two-bit presence code and the two power-fault signals. It records each change as a sticky event bit and gates those bits with per-event masks. Slot state, indicator state and speed capability come from the neighbouring command logic and are shown in the slot register without change.

Software reaches the block through a flat 32-bit register port with combinational reads and single-cycle writes. It can read a configuration word, an interrupt locator word, a controller-wide mask/detect register and one register per slot. The locator word tells the handler in one read which slots need service and whether a command has completed. The handler then clears the events it has handled by writing ones to them.

Top module: `slot_evt_ctrl`

## Requirements
- R1: After reset every interrupt and error mask bit reads 1, every event bit reads 0, the controller register at 0x08 reads 0x0000000F, the locator reads 0, and `irq_o` and `serr_o` are low.
- R2: A slot register holds, from bit 0 upward: slot state [1:0], power indicator [3:2], attention indicator [5:4], power-good [6] (0 while either power-fault input is high), button level [7], latch-open level [8], 66 MHz capable [9], presence code [11:10] and speed capability [14:12]. Bits 14:0 are read-only.
- R3: Event bits are presence change (16), isolated power fault (17), button press (18), latch change (19) and connected power fault (20). Each is set by any change of its synchronised input, except the button event, which is set only on a rising edge. The bit reads 1 from the third rising clock edge after the input changes.
- R4: Writing 1 to a slot event bit clears it and writing 0 leaves it. If the hardware sets a bit in the same cycle that software clears it, the bit reads 1.
- R5: Slot bits 28:24 are read/write interrupt masks for events 16..20 in the same order. Bit 29 masks the error for latch change and bit 30 masks the error for connected power fault. Bits 31, 23:21 and 15 read 0 and ignore writes.
- R6: The locator word at 0x04 has bit 0 set while the command-detected bit is 1 and the command interrupt mask is 0. It has bit i+1 set while slot i holds any event whose interrupt mask is 0. All other bits read 0.
- R7: `irq_o` is high exactly when the locator word is nonzero and the global interrupt mask (controller bit 0) is 0. Setting that mask leaves every event bit unchanged, so clearing it raises `irq_o` again.
- R8: `serr_o` is high exactly when the global error mask (controller bit 1) is 0 and at least one of these holds: the arbiter-detected bit is 1 with the arbiter mask (bit 3) at 0; a slot's latch-change event is 1 with its bit 29 at 0; or a slot's connected-fault event is 1 with its bit 30 at 0.
- R9: In the controller register, bits 3:0 are read/write masks (global interrupt, global error, command interrupt, arbiter error). A `cmd_done_i` pulse sets bit 16 and an `arb_err_i` pulse sets bit 17 on the next edge. Both bits clear when 1 is written to them, the hardware set wins over the clear, and bits 31:18 and 15:4 read 0.
- R10: The word at 0x00 reads the slot count in bits 4:0 and 0 elsewhere. Slot i sits at 0x10 + 4*i. Every other address reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | ADDR_W | Byte address of the register access |
| reg_wr_i | input | 1 | Write strobe, takes effect at the next rising edge |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| cmd_done_i | input | 1 | Command-completion pulse from the command logic |
| arb_err_i | input | 1 | Arbiter error pulse |
| latch_open_i | input | NUM_SLOTS | Retention latch open level per slot, asynchronous |
| button_i | input | NUM_SLOTS | Attention button level per slot, asynchronous |
| presence_i | input | 2*NUM_SLOTS | Presence code per slot (3 = empty), asynchronous |
| iso_fault_i | input | NUM_SLOTS | Isolated power-fault level per slot, asynchronous |
| con_fault_i | input | NUM_SLOTS | Connected power-fault level per slot, asynchronous |
| slot_state_i | input | 2*NUM_SLOTS | Slot state per slot (1 powered-only, 2 enabled, 3 disabled) |
| pwr_ind_i | input | 2*NUM_SLOTS | Power indicator per slot (1 on, 2 blink, 3 off) |
| attn_ind_i | input | 2*NUM_SLOTS | Attention indicator per slot (1 on, 2 blink, 3 off) |
| cap66_i | input | NUM_SLOTS | 66 MHz capability per slot |
| speed_cap_i | input | 3*NUM_SLOTS | Adapter speed capability per slot |
| irq_o | output | 1 | Level interrupt request |
| serr_o | output | 1 | System-error request |

## Verification
The bound checker checks the following on every cycle. A pending slot interrupt or command-detected bit must survive any cycle without a register write. A completion pulse must always be captured. A write to the global mask must take effect on the next cycle. Both outputs must fall silent while their global mask is set, and the reserved slot bits must never read 1. The bench scenarios show what depends on history and timing: the latency through the synchronisers, the button's edge rule, the race between a hardware set and a software clear, and re-assertion after the global mask is lifted. The randomised mix of input toggles, clears and mask writes, compared against a bench model, exercises the interplay of the masks with the locator word.

// File: rtl/slot_evt_pkg.sv
package slot_evt_pkg;

    localparam int REG_W     = 32;
    localparam int EVT_N     = 5;
    localparam int EVT_LSB   = 16;
    localparam int IMASK_LSB = 24;
    localparam int SMASK_LSB = 29;

    // event index order, equal to bit order above EVT_LSB
    localparam int EV_PRES  = 0;
    localparam int EV_ISO   = 1;
    localparam int EV_BTN   = 2;
    localparam int EV_LATCH = 3;
    localparam int EV_CON   = 4;

    // controller mask bits
    localparam int GM_INT  = 0;
    localparam int GM_SERR = 1;
    localparam int GM_CMD  = 2;
    localparam int GM_ARB  = 3;

    localparam int CFG_OFS   = 'h00;
    localparam int LOC_OFS   = 'h04;
    localparam int GLOB_OFS  = 'h08;
    localparam int SLOT_BASE = 'h10;

    typedef struct packed {
        logic       con;
        logic       iso;
        logic [1:0] pres;
        logic       btn;
        logic       latch;
    } slot_in_t;

    localparam int SLOT_IN_W = $bits(slot_in_t);

    typedef struct packed {
        logic [EVT_N-1:0] evt;
        logic [EVT_N-1:0] imask;
        logic [1:0]       smask;
    } slot_regs_t;

    typedef struct packed {
        logic [3:0] mask;
        logic       cmd_det;
        logic       arb_det;
    } glob_regs_t;

endpackage

// File: rtl/slot_evt_sync.sv
module slot_evt_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o,
    output logic         valid_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
        logic [2:0]   vld;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.s1  = in_i;
        st_d.s2  = st_q.s1;
        st_d.s3  = st_q.s2;
        st_d.vld = {st_q.vld[1:0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_o   = st_q.s2;
    assign prev_o  = st_q.s3;
    assign valid_o = st_q.vld[2];

endmodule

// File: rtl/slot_evt_slot.sv
module slot_evt_slot
    import slot_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [14:0]      wfield_i,   // write data bits 30:16
    input  slot_in_t         raw_i,
    input  logic [1:0]       state_i,
    input  logic [1:0]       pwr_i,
    input  logic [1:0]       attn_i,
    input  logic             cap66_i,
    input  logic [2:0]       spd_i,
    output logic [REG_W-1:0] rdata_o,
    output logic             int_pend_o,
    output logic             serr_pend_o
);

    logic [SLOT_IN_W-1:0] cur_v, prev_v;
    logic                 smp_vld;
    slot_in_t             cur_s, prev_s;
    logic [EVT_N-1:0]     hw_set;
    logic [EVT_N-1:0]     sw_clr;

    slot_regs_t reg_d, reg_q;

    slot_evt_sync #(.W(SLOT_IN_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_i    (raw_i),
        .cur_o   (cur_v),
        .prev_o  (prev_v),
        .valid_o (smp_vld)
    );

    assign cur_s  = slot_in_t'(cur_v);
    assign prev_s = slot_in_t'(prev_v);

    always_comb begin
        hw_set           = '0;
        hw_set[EV_PRES]  = cur_s.pres  != prev_s.pres;
        hw_set[EV_ISO]   = cur_s.iso   != prev_s.iso;
        hw_set[EV_BTN]   = cur_s.btn   & ~prev_s.btn;
        hw_set[EV_LATCH] = cur_s.latch != prev_s.latch;
        hw_set[EV_CON]   = cur_s.con   != prev_s.con;
        if (!smp_vld) hw_set = '0;
    end

    assign sw_clr = wr_i ? wfield_i[EVT_N-1:0] : '0;

    always_comb begin
        reg_d     = reg_q;
        reg_d.evt = (reg_q.evt & ~sw_clr) | hw_set;
        if (wr_i) begin
            reg_d.imask = wfield_i[IMASK_LSB-EVT_LSB +: EVT_N];
            reg_d.smask = wfield_i[SMASK_LSB-EVT_LSB +: 2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q.evt   <= '0;
            reg_q.imask <= '1;
            reg_q.smask <= '1;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign rdata_o = {1'b0, reg_q.smask, reg_q.imask, 3'b000, reg_q.evt,
                      1'b0, spd_i, cur_s.pres, cap66_i, cur_s.latch, cur_s.btn,
                      ~(cur_s.iso | cur_s.con), attn_i, pwr_i, state_i};

    assign int_pend_o  = |(reg_q.evt & ~reg_q.imask);
    assign serr_pend_o = (reg_q.evt[EV_LATCH] & ~reg_q.smask[0])
                       | (reg_q.evt[EV_CON]   & ~reg_q.smask[1]);

endmodule

// File: rtl/slot_evt_glob.sv
module slot_evt_glob
    import slot_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [3:0]       mask_w_i,
    input  logic [1:0]       clr_w_i,    // write data bits 17:16
    input  logic             cmd_done_i,
    input  logic             arb_err_i,
    output logic [REG_W-1:0] rdata_o,
    output logic             gint_mask_o,
    output logic             gserr_mask_o,
    output logic             cmd_det_o,
    output logic             cmd_imask_o,
    output logic             arb_serr_o
);

    glob_regs_t reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (wr_i) reg_d.mask = mask_w_i;
        reg_d.cmd_det = (reg_q.cmd_det & ~(wr_i & clr_w_i[0])) | cmd_done_i;
        reg_d.arb_det = (reg_q.arb_det & ~(wr_i & clr_w_i[1])) | arb_err_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q.mask    <= '1;
            reg_q.cmd_det <= 1'b0;
            reg_q.arb_det <= 1'b0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign rdata_o      = {14'b0, reg_q.arb_det, reg_q.cmd_det, 12'b0, reg_q.mask};
    assign gint_mask_o  = reg_q.mask[GM_INT];
    assign gserr_mask_o = reg_q.mask[GM_SERR];
    assign cmd_det_o    = reg_q.cmd_det;
    assign cmd_imask_o  = reg_q.mask[GM_CMD];
    assign arb_serr_o   = reg_q.arb_det & ~reg_q.mask[GM_ARB];

endmodule

// File: rtl/slot_evt_ctrl.sv
module slot_evt_ctrl
    import slot_evt_pkg::*;
#(
    parameter int NUM_SLOTS = 4,    // 1..30
    parameter int ADDR_W    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      reg_addr_i,
    input  logic                   reg_wr_i,
    input  logic [REG_W-1:0]       reg_wdata_i,
    output logic [REG_W-1:0]       reg_rdata_o,
    input  logic                   cmd_done_i,
    input  logic                   arb_err_i,
    input  logic [NUM_SLOTS-1:0]   latch_open_i,
    input  logic [NUM_SLOTS-1:0]   button_i,
    input  logic [2*NUM_SLOTS-1:0] presence_i,
    input  logic [NUM_SLOTS-1:0]   iso_fault_i,
    input  logic [NUM_SLOTS-1:0]   con_fault_i,
    input  logic [2*NUM_SLOTS-1:0] slot_state_i,
    input  logic [2*NUM_SLOTS-1:0] pwr_ind_i,
    input  logic [2*NUM_SLOTS-1:0] attn_ind_i,
    input  logic [NUM_SLOTS-1:0]   cap66_i,
    input  logic [3*NUM_SLOTS-1:0] speed_cap_i,
    output logic                   irq_o,
    output logic                   serr_o
);

    localparam int LOC_W = NUM_SLOTS + 1;

    logic [NUM_SLOTS-1:0] slot_wr;
    logic [NUM_SLOTS-1:0] slot_int;
    logic [NUM_SLOTS-1:0] slot_serr;
    logic [REG_W-1:0]     slot_rd [NUM_SLOTS];

    logic             glob_wr;
    logic [REG_W-1:0] glob_rd;
    logic             gint_mask, gserr_mask, cmd_det, cmd_imask, arb_serr;
    logic [REG_W-1:0] loc_word;
    logic [REG_W-1:0] cfg_word;
    logic             unused_wbits;

    assign unused_wbits = ^{reg_wdata_i[31], reg_wdata_i[15:4]};

    assign glob_wr = reg_wr_i && (reg_addr_i == ADDR_W'(GLOB_OFS));

    slot_evt_glob u_glob (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (glob_wr),
        .mask_w_i     (reg_wdata_i[3:0]),
        .clr_w_i      (reg_wdata_i[17:16]),
        .cmd_done_i   (cmd_done_i),
        .arb_err_i    (arb_err_i),
        .rdata_o      (glob_rd),
        .gint_mask_o  (gint_mask),
        .gserr_mask_o (gserr_mask),
        .cmd_det_o    (cmd_det),
        .cmd_imask_o  (cmd_imask),
        .arb_serr_o   (arb_serr)
    );

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        slot_in_t raw;
        assign raw.con   = con_fault_i[i];
        assign raw.iso   = iso_fault_i[i];
        assign raw.pres  = presence_i[2*i +: 2];
        assign raw.btn   = button_i[i];
        assign raw.latch = latch_open_i[i];

        assign slot_wr[i] = reg_wr_i && (reg_addr_i == ADDR_W'(SLOT_BASE + 4*i));

        slot_evt_slot u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_i        (slot_wr[i]),
            .wfield_i    (reg_wdata_i[30:16]),
            .raw_i       (raw),
            .state_i     (slot_state_i[2*i +: 2]),
            .pwr_i       (pwr_ind_i[2*i +: 2]),
            .attn_i      (attn_ind_i[2*i +: 2]),
            .cap66_i     (cap66_i[i]),
            .spd_i       (speed_cap_i[3*i +: 3]),
            .rdata_o     (slot_rd[i]),
            .int_pend_o  (slot_int[i]),
            .serr_pend_o (slot_serr[i])
        );
    end

    assign loc_word = {{(REG_W-LOC_W){1'b0}}, slot_int, cmd_det & ~cmd_imask};
    assign cfg_word = {27'b0, 5'(NUM_SLOTS)};

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == ADDR_W'(CFG_OFS))       reg_rdata_o = cfg_word;
        else if (reg_addr_i == ADDR_W'(LOC_OFS))  reg_rdata_o = loc_word;
        else if (reg_addr_i == ADDR_W'(GLOB_OFS)) reg_rdata_o = glob_rd;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (reg_addr_i == ADDR_W'(SLOT_BASE + 4*i)) reg_rdata_o = slot_rd[i];
        end
    end

    assign irq_o  = (|loc_word) & ~gint_mask;
    assign serr_o = ~gserr_mask & (arb_serr | (|slot_serr));

endmodule

// File: rtl/slot_evt_chk.sv
module slot_evt_chk
    import slot_evt_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    reg_addr_i,
    input logic                 reg_wr_i,
    input logic                 wbit0,
    input logic [4:0]           rd_rsvd,
    input logic                 cmd_done_i,
    input logic                 irq_o,
    input logic                 serr_o,
    input logic [NUM_SLOTS-1:0] slot_int,
    input logic                 cmd_det,
    input logic                 gint_mask,
    input logic                 gserr_mask
);

    logic in_slot_range;
    assign in_slot_range = (32'(reg_addr_i) >= SLOT_BASE)
                        && (32'(reg_addr_i) < SLOT_BASE + 4*NUM_SLOTS)
                        && (reg_addr_i[1:0] == 2'b00);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_sticky
        // R4
        slot_pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_int[i] && !reg_wr_i) |=> slot_int[i]);
    end

    // R9
    cmd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done_i |=> cmd_det);

    // R9
    cmd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_det && !reg_wr_i) |=> cmd_det);

    // R5
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_slot_range |-> (rd_rsvd == 5'b0));

    // R7
    gmask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == ADDR_W'(GLOB_OFS)) |=> (gint_mask == $past(wbit0)));

    // R7
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !gint_mask);

    // R8
    serr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serr_o |-> !gserr_mask);

endmodule

bind slot_evt_ctrl slot_evt_chk #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr_i (reg_addr_i),
    .reg_wr_i   (reg_wr_i),
    .wbit0      (reg_wdata_i[0]),
    .rd_rsvd    ({reg_rdata_o[31], reg_rdata_o[23:21], reg_rdata_o[15]}),
    .cmd_done_i (cmd_done_i),
    .irq_o      (irq_o),
    .serr_o     (serr_o),
    .slot_int   (slot_int),
    .cmd_det    (cmd_det),
    .gint_mask  (gint_mask),
    .gserr_mask (gserr_mask)
);

// File: tb/slot_evt_ctrl_test.sv
`timescale 1ns/1ps
module slot_evt_ctrl_test;

    localparam int N = 4;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0]  reg_addr = '0;
    logic           reg_wr = 1'b0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic           cmd_done = 1'b0, arb_err = 1'b0;
    logic [N-1:0]   latch_open = '0, button = '0, iso_f = '0, con_f = '0, cap66 = '0;
    logic [2*N-1:0] presence = '1, sstate = '0, pwr_ind = '0, attn_ind = '0;
    logic [3*N-1:0] spd = '0;
    logic           irq, serr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    logic [4:0] m_evt [N];
    logic [4:0] m_imask [N];
    logic [1:0] m_smask [N];
    logic [3:0] m_gmask;
    logic       m_cmd, m_arb;

    always #2.5 clk = ~clk;

    slot_evt_ctrl #(.NUM_SLOTS(N), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .cmd_done_i(cmd_done),
        .arb_err_i(arb_err), .latch_open_i(latch_open), .button_i(button),
        .presence_i(presence), .iso_fault_i(iso_f), .con_fault_i(con_f),
        .slot_state_i(sstate), .pwr_ind_i(pwr_ind), .attn_ind_i(attn_ind),
        .cap66_i(cap66), .speed_cap_i(spd), .irq_o(irq), .serr_o(serr)
    );

    function automatic logic [31:0] exp_slot(int s);
        return {1'b0, m_smask[s], m_imask[s], 3'b000, m_evt[s], 1'b0, spd[3*s +: 3],
                presence[2*s +: 2], cap66[s], latch_open[s], button[s],
                ~(iso_f[s] | con_f[s]), attn_ind[2*s +: 2], pwr_ind[2*s +: 2],
                sstate[2*s +: 2]};
    endfunction

    function automatic logic [31:0] exp_loc();
        logic [31:0] v = '0;
        v[0] = m_cmd & ~m_gmask[2];
        for (int s = 0; s < N; s++) v[s+1] = |(m_evt[s] & ~m_imask[s]);
        return v;
    endfunction

    function automatic logic exp_irq();
        return (|exp_loc()) & ~m_gmask[0];
    endfunction

    function automatic logic exp_serr();
        logic any = m_arb & ~m_gmask[3];
        for (int s = 0; s < N; s++)
            any |= (m_evt[s][3] & ~m_smask[s][0]) | (m_evt[s][4] & ~m_smask[s][1]);
        return any & ~m_gmask[1];
    endfunction

    function automatic logic [31:0] exp_glob();
        return {14'b0, m_arb, m_cmd, 12'b0, m_gmask};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input int addr, output logic [31:0] v);
        @(negedge clk);
        reg_addr = AW'(addr);
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input int addr, input logic [31:0] v);
        @(negedge clk);
        reg_addr = AW'(addr);
        reg_wdata = v;
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic slot_write(input int s, input logic [31:0] v);
        wr('h10 + 4*s, v);
        m_evt[s]   = m_evt[s] & ~v[20:16];
        m_imask[s] = v[28:24];
        m_smask[s] = v[30:29];
    endtask

    task automatic glob_write(input logic [31:0] v);
        wr('h08, v);
        m_gmask = v[3:0];
        if (v[16]) m_cmd = 1'b0;
        if (v[17]) m_arb = 1'b0;
    endtask

    // toggle one slot input: 0 latch, 1 button, 2 presence, 3 iso, 4 con
    task automatic poke(input int s, input int kind);
        @(negedge clk);
        case (kind)
            0: begin latch_open[s] = ~latch_open[s]; m_evt[s][3] = 1'b1; end
            1: begin button[s] = ~button[s]; if (button[s]) m_evt[s][2] = 1'b1; end
            2: begin presence[2*s +: 2] = presence[2*s +: 2] ^ 2'(1 + $urandom % 3);
                     m_evt[s][0] = 1'b1; end
            3: begin iso_f[s] = ~iso_f[s]; m_evt[s][1] = 1'b1; end
            default: begin con_f[s] = ~con_f[s]; m_evt[s][4] = 1'b1; end
        endcase
        repeat (4) @(negedge clk);
    endtask

    task automatic check_slot(input int s, input string req);
        logic [31:0] v;
        rd('h10 + 4*s, v); chk(req, v, exp_slot(s));
        rd('h04, v);       chk({req, " locator"}, v, exp_loc());
        #1;
        chk({req, " irq"},  {31'b0, irq},  {31'b0, exp_irq()});
        chk({req, " serr"}, {31'b0, serr}, {31'b0, exp_serr()});
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5EED1));
        for (int s = 0; s < N; s++) begin
            m_evt[s] = '0; m_imask[s] = '1; m_smask[s] = '1;
        end
        m_gmask = 4'hF; m_cmd = 1'b0; m_arb = 1'b0;
        sstate = 8'b11_10_01_11; pwr_ind = 8'b01_10_11_01;
        attn_ind = 8'b11_01_10_10; cap66 = 4'b1010; spd = 12'o5316;
        presence = 8'b11_01_11_10;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 / R10 reset state and map
        rd('h00, v); chk("R10 cfg", v, 32'(N));
        rd('h08, v); chk("R1 glob reset", v, 32'h0000_000F);
        rd('h0C, v); chk("R10 unmapped", v, 32'h0);
        for (int s = 0; s < N; s++) check_slot(s, "R1 slot reset");

        // R2 status field layout with a fault applied
        @(negedge clk); iso_f[1] = 1'b1; repeat (4) @(negedge clk);
        m_evt[1][1] = 1'b1;
        rd('h14, v); chk("R2 power-good low on fault", {31'b0, v[6]}, 32'h0);
        chk("R2 full layout", v, exp_slot(1));

        // R3 button falling edge does not set an event
        poke(0, 1);
        slot_write(0, {1'b0, 2'b11, 5'h1F, 3'b0, 5'h1F, 16'h0});
        poke(0, 1);
        rd('h10, v); chk("R3 no event on release", {27'b0, v[20:16]}, 32'h0);

        // R5 write all ones: reserved bits stay zero
        slot_write(2, 32'hFFFF_FFFF);
        rd('h18, v);
        chk("R5 reserved zero", {28'b0, v[31], v[23], v[22], v[15]}, 32'h0);
        chk("R5 masks set", v, exp_slot(2));

        // R4 hardware set wins against a same-cycle clear
        slot_write(2, {1'b0, 2'b00, 5'h00, 3'b0, 5'h1F, 16'h0});
        glob_write(32'h0000_0000);
        @(negedge clk); latch_open[2] = ~latch_open[2];
        @(negedge clk);
        @(negedge clk);
        reg_addr = AW'('h18); reg_wdata = {1'b0, 2'b00, 5'h00, 3'b0, 5'h1F, 16'h0}; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
        m_evt[2] = 5'b01000;
        check_slot(2, "R4 set beats clear");
        check_slot(2, "R8 latch change error");

        // R7 global mask holds events, lifting it restores irq
        glob_write(32'h0000_0001);
        #1; chk("R7 irq masked", {31'b0, irq}, 32'h0);
        rd('h04, v); chk("R7 locator kept", v, exp_loc());
        glob_write(32'h0000_0000);
        #1; chk("R7 irq returns", {31'b0, irq}, {31'b0, exp_irq()});

        // R9 / R6 command completion and its clear
        @(negedge clk); cmd_done = 1'b1; @(negedge clk); cmd_done = 1'b0; m_cmd = 1'b1;
        rd('h04, v); chk("R6 cmd locator bit", {31'b0, v[0]}, 32'h1);
        rd('h08, v); chk("R9 cmd detected", v, exp_glob());
        glob_write(32'h0001_0000);
        rd('h08, v); chk("R9 cmd cleared", v, exp_glob());

        // R8 arbiter error path
        @(negedge clk); arb_err = 1'b1; @(negedge clk); arb_err = 1'b0; m_arb = 1'b1;
        #1; chk("R8 arbiter serr", {31'b0, serr}, {31'b0, exp_serr()});
        glob_write(32'h0002_0002);
        #1; chk("R8 serr masked", {31'b0, serr}, 32'h0);

        // random mix
        for (int it = 0; it < 150; it++) begin
            int s = $urandom % N;
            int k = $urandom % 9;
            if (k < 5) poke(s, k);
            else if (k == 5) slot_write(s, $urandom);
            else if (k == 6) slot_write(s, {1'b0, $urandom} & 32'h7F1F_0000);
            else if (k == 7) glob_write($urandom & 32'h0003_000F);
            else begin
                @(negedge clk);
                if ($urandom % 2) begin cmd_done = 1'b1; m_cmd = 1'b1; end
                else begin arb_err = 1'b1; m_arb = 1'b1; end
                @(negedge clk); cmd_done = 1'b0; arb_err = 1'b0;
            end
            check_slot(s, "R3 R6 random");
            rd('h08, v); chk("R9 random glob", v, exp_glob());
        end

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule